// File: doc/BRIEF.md
# Link Transmit Framer with CRC

This block takes trigger data produced in a slow system-clock domain and hands it to a faster, unrelated link clock domain. It then emits a stream of 16-bit words toward an external 8B/10B serializer. Two consecutive system-side words make one frame. The domain crossing is a shallow dual-clock buffer with Gray-coded pointers, which keeps the latency low. The read side cuts each frame into four link words and closes it with a CRC-16 word.

The link clock is faster than the payload rate, so slots with nothing to carry are filled with a comma word. The data-enable qualifier is low on those slots, and the receiver discards them. Every frame is preceded by one lead comma. The high byte of that comma tells the receiver whether the frame carries the bunch-crossing-zero marker, which it uses to align latency. The block holds the link in comma-only idle until the buffer contains a complete frame.

Top module: `ltx_link_framer`

## Requirements
- R1: While the link side is in reset, and on every slot that carries no frame word, the outputs are `tx_data` = 16'h50BC (K28.5 = 0xBC in the low byte), `tx_k` = 2'b01 (bit 0 flags the low byte) and `tx_de` = 0. The only exception is the lead comma, whose high byte is set by R6.
- R2: No frame word leaves the block until both system words of that frame are in the buffer. After one word has been written, the link stays in comma idle for as long as the second word is missing.
- R3: Valid input words pair in arrival order. The first valid word after reset opens a frame, the next one closes it, and gaps between the two words do not break the pairing.
- R4: A frame's payload goes out as first[31:16], first[15:0], second[31:16], second[15:0], each with `tx_de` = 1 and `tx_k` = 2'b00.
- R5: The fifth word of a frame is a CRC-16 with polynomial 0x1021 and seed 0xFFFF, with no final inversion. It is computed MSB first over the 64 payload bits in the order of R4 and sent with `tx_de` = 1 and `tx_k` = 2'b00.
- R6: Each frame is preceded by exactly one lead comma with `tx_de` = 0 and `tx_k` = 2'b01. Its high byte is 0xC5 when `in_bc0` was high with the frame's first word, and 0x50 otherwise. `in_bc0` sampled with the second word has no effect.
- R7: Frames come out in input order, with none lost or repeated. This holds for back-to-back input frames and for any gap between frames, provided the source never writes into a full buffer.
- R8: The source never presents a valid word while the buffer is full. This is an environment obligation that the block watches.
- R9: Once `tx_de` rises it stays high for exactly five slots, then falls for at least one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System-side clock (payload domain) |
| sys_rst_n | input | 1 | Active-low asynchronous reset, system side |
| in_valid | input | 1 | Qualifies `in_data` for one system cycle |
| in_data | input | SYS_W | Payload word; two make one frame |
| in_bc0 | input | 1 | Bunch-crossing-zero flag, taken with a frame's first word |
| lnk_clk | input | 1 | Link clock, faster and asynchronous to `sys_clk` |
| lnk_rst_n | input | 1 | Active-low asynchronous reset, link side |
| tx_data | output | 16 | Word toward the 8B/10B serializer |
| tx_k | output | 2 | Per-byte control-character flags |
| tx_de | output | 1 | High on payload and CRC slots, low on commas |

## Verification
The bench builds the block with a 32-bit system word and a 3-bit buffer address, which gives eight entries, or four frames. The system clock runs at 20 ns and the link clock at 6 ns with an offset, so their edges never line up. At these ratios back-to-back input frames come close to the link's six-slot drain time. Sweeping inter-frame gaps of zero to three cycles therefore drives the buffer near its full boundary, while a held half frame exercises the one-word wait. Because the buffer is this small, pointer wrap and Gray-code crossing are reached many times during a sweep of a little over a hundred frames.

// File: rtl/ltx_pkg.sv
`timescale 1ns/1ps
package ltx_pkg;
  localparam int unsigned LINK_W = 16;
  localparam int unsigned KW     = LINK_W / 8;

  localparam logic [7:0]  K28_5    = 8'hBC;
  localparam logic [7:0]  FILL_HI  = 8'h50;
  localparam logic [7:0]  BC0_HI   = 8'hC5;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  localparam logic [LINK_W-1:0] IDLE_WORD = {FILL_HI, K28_5};
  localparam logic [KW-1:0]     K_LOW     = {{(KW-1){1'b0}}, 1'b1};

  // Advance a CRC-16 register over one link word, MSB first.
  function automatic logic [15:0] crc16_word(input logic [15:0] crc, input logic [15:0] d);
    logic [15:0] c;
    c = crc;
    for (int i = 15; i >= 0; i--) begin
      if (c[15] ^ d[i]) c = {c[14:0], 1'b0} ^ CRC_POLY;
      else              c = {c[14:0], 1'b0};
    end
    return c;
  endfunction

  // Lead comma: marks the slot in front of each frame.
  function automatic logic [LINK_W-1:0] lead_word(input logic bc0);
    return {(bc0 ? BC0_HI : FILL_HI), K28_5};
  endfunction
endpackage

// File: rtl/ltx_gray_sync.sv
`timescale 1ns/1ps
module ltx_gray_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ltx_cdc_fifo.sv
`timescale 1ns/1ps
module ltx_cdc_fifo #(
  parameter int unsigned DW = 33,
  parameter int unsigned AW = 3
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_pop,
  output logic [DW-1:0] rd_head0,
  output logic [DW-1:0] rd_head1,
  output logic          rd_pair_ok
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned PW    = AW + 1;

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // write side
  logic [PW-1:0] wbin, wgray, rgray_w;
  logic [PW-1:0] wbin_nx;
  assign wbin_nx = wbin + PW'(1);

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_en) begin
      wbin  <= wbin_nx;
      wgray <= bin2gray(wbin_nx);
    end
  end

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wbin[AW-1:0]] <= wr_data;
  end

  ltx_gray_sync #(.W(PW)) u_rsync (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_w)
  );

  assign wr_full = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});

  // read side
  logic [PW-1:0] rbin, rgray, wgray_r, rbin_nx, avail;
  logic [AW-1:0] raddr1;
  assign rbin_nx = rbin + PW'(1);
  assign raddr1  = rbin[AW-1:0] + AW'(1);

  ltx_gray_sync #(.W(PW)) u_wsync (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_r)
  );

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_pop) begin
      rbin  <= rbin_nx;
      rgray <= bin2gray(rbin_nx);
    end
  end

  assign avail      = gray2bin(wgray_r) - rbin;
  assign rd_pair_ok = (avail >= PW'(2));
  assign rd_head0   = mem[rbin[AW-1:0]];
  assign rd_head1   = mem[raddr1];
endmodule

// File: rtl/ltx_frame_tx.sv
`timescale 1ns/1ps
module ltx_frame_tx
  import ltx_pkg::*;
#(
  parameter int unsigned SYS_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pair_ok,
  input  logic [SYS_W:0]    head0,
  input  logic [SYS_W:0]    head1,
  output logic              pop,
  output logic              ev_start,
  output logic              ev_crc,
  output logic [LINK_W-1:0] tx_data,
  output logic [KW-1:0]     tx_k,
  output logic              tx_de
);
  localparam int unsigned LANES  = SYS_W / LINK_W;
  localparam int unsigned NWORDS = 2 * LANES;
  localparam int unsigned SW     = $clog2(NWORDS + 1);
  localparam int unsigned FW     = 2 * SYS_W;
  localparam logic [SW-1:0] LAST = SW'(NWORDS);

  logic          busy;
  logic [SW-1:0] slot;
  logic [FW-1:0] frm;
  logic [15:0]   crc;

  logic [LINK_W-1:0] cur_word;
  logic [15:0]       crc_nx;
  logic              unused_second_bc0;

  assign unused_second_bc0 = head1[SYS_W];
  assign cur_word = frm[FW-1 -: LINK_W];
  assign crc_nx   = crc16_word(crc, cur_word);
  assign ev_start = !busy && pair_ok;
  assign ev_crc   = busy && (slot == LAST);
  assign pop      = ev_start || (busy && (slot == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      slot    <= '0;
      frm     <= '0;
      crc     <= CRC_SEED;
      tx_data <= IDLE_WORD;
      tx_k    <= K_LOW;
      tx_de   <= 1'b0;
    end else if (ev_start) begin
      busy    <= 1'b1;
      slot    <= '0;
      frm     <= {head0[SYS_W-1:0], head1[SYS_W-1:0]};
      crc     <= CRC_SEED;
      tx_data <= lead_word(head0[SYS_W]);
      tx_k    <= K_LOW;
      tx_de   <= 1'b0;
    end else if (ev_crc) begin
      busy    <= 1'b0;
      tx_data <= crc;
      tx_k    <= '0;
      tx_de   <= 1'b1;
    end else if (busy) begin
      slot    <= slot + SW'(1);
      frm     <= {frm[FW-LINK_W-1:0], {LINK_W{1'b0}}};
      crc     <= crc_nx;
      tx_data <= cur_word;
      tx_k    <= '0;
      tx_de   <= 1'b1;
    end else begin
      tx_data <= IDLE_WORD;
      tx_k    <= K_LOW;
      tx_de   <= 1'b0;
    end
  end
endmodule

// File: rtl/ltx_link_framer.sv
`timescale 1ns/1ps
module ltx_link_framer
  import ltx_pkg::*;
#(
  parameter int unsigned SYS_W = 32,
  parameter int unsigned AW    = 3
) (
  input  logic             sys_clk,
  input  logic             sys_rst_n,
  input  logic             in_valid,
  input  logic [SYS_W-1:0] in_data,
  input  logic             in_bc0,
  input  logic             lnk_clk,
  input  logic             lnk_rst_n,
  output logic [15:0]      tx_data,
  output logic [1:0]       tx_k,
  output logic             tx_de
);
  localparam int unsigned NWORDS = 2 * (SYS_W / LINK_W);
  localparam int unsigned DW     = SYS_W + 1;

  // pairing on the write side: the BC0 flag travels with a frame's first word
  logic          wr_second;
  logic [DW-1:0] wr_entry;
  logic          wr_full;

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n)    wr_second <= 1'b0;
    else if (in_valid) wr_second <= !wr_second;
  end

  assign wr_entry = {in_bc0 & !wr_second, in_data};

  logic          pair_ok, pop, ev_start, ev_crc;
  logic [DW-1:0] head0, head1;

  ltx_cdc_fifo #(.DW(DW), .AW(AW)) u_fifo (
    .wr_clk    (sys_clk),
    .wr_rst_n  (sys_rst_n),
    .wr_en     (in_valid),
    .wr_data   (wr_entry),
    .wr_full   (wr_full),
    .rd_clk    (lnk_clk),
    .rd_rst_n  (lnk_rst_n),
    .rd_pop    (pop),
    .rd_head0  (head0),
    .rd_head1  (head1),
    .rd_pair_ok(pair_ok)
  );

  ltx_frame_tx #(.SYS_W(SYS_W)) u_tx (
    .clk     (lnk_clk),
    .rst_n   (lnk_rst_n),
    .pair_ok (pair_ok),
    .head0   (head0),
    .head1   (head1),
    .pop     (pop),
    .ev_start(ev_start),
    .ev_crc  (ev_crc),
    .tx_data (tx_data),
    .tx_k    (tx_k),
    .tx_de   (tx_de)
  );
endmodule

// File: rtl/ltx_checker.sv
`timescale 1ns/1ps
module ltx_checker
  import ltx_pkg::*;
#(
  parameter int unsigned NWORDS = 4
) (
  input logic        sys_clk,
  input logic        sys_rst_n,
  input logic        in_valid,
  input logic        wr_full,
  input logic        lnk_clk,
  input logic        lnk_rst_n,
  input logic        ev_start,
  input logic        ev_crc,
  input logic [15:0] tx_data,
  input logic [1:0]  tx_k,
  input logic        tx_de
);
  logic [3:0] run;

  always_ff @(posedge lnk_clk or negedge lnk_rst_n) begin
    if (!lnk_rst_n) run <= '0;
    else            run <= tx_de ? run + 4'd1 : 4'd0;
  end

  AST_NO_OVERFLOW: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    in_valid |-> !wr_full); // R8

  AST_IDLE_IS_COMMA: assert property (@(posedge lnk_clk) disable iff (!lnk_rst_n)
    !tx_de |-> (tx_k == 2'b01 && tx_data[7:0] == K28_5 &&
                (tx_data[15:8] == FILL_HI || tx_data[15:8] == BC0_HI))); // R1

  AST_DATA_NO_K: assert property (@(posedge lnk_clk) disable iff (!lnk_rst_n)
    tx_de |-> (tx_k == 2'b00)); // R4

  AST_CRC_AFTER_PAYLOAD: assert property (@(posedge lnk_clk) disable iff (!lnk_rst_n)
    ev_crc |-> (tx_de && run == 4'(NWORDS - 1))); // R5

  AST_FRAME_CLOSES: assert property (@(posedge lnk_clk) disable iff (!lnk_rst_n)
    (tx_de && run == 4'(NWORDS)) |=> !tx_de); // R9

  AST_FRAME_FULL: assert property (@(posedge lnk_clk) disable iff (!lnk_rst_n)
    $fell(tx_de) |-> ($past(run) == 4'(NWORDS))); // R9

  AST_LEAD_COMMA: assert property (@(posedge lnk_clk) disable iff (!lnk_rst_n)
    $rose(tx_de) |-> $past(ev_start, 2)); // R6
endmodule

bind ltx_link_framer ltx_checker #(.NWORDS(NWORDS)) u_chk (
  .sys_clk  (sys_clk),
  .sys_rst_n(sys_rst_n),
  .in_valid (in_valid),
  .wr_full  (wr_full),
  .lnk_clk  (lnk_clk),
  .lnk_rst_n(lnk_rst_n),
  .ev_start (ev_start),
  .ev_crc   (ev_crc),
  .tx_data  (tx_data),
  .tx_k     (tx_k),
  .tx_de    (tx_de)
);

// File: tb/tb_ltx_link_framer.sv
`timescale 1ns/1ps
module tb_ltx_link_framer;
  logic        sys_clk = 1'b0;
  logic        lnk_clk = 1'b0;
  logic        sys_rst_n = 1'b0;
  logic        lnk_rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_bc0 = 1'b0;
  logic [15:0] tx_data;
  logic [1:0]  tx_k;
  logic        tx_de;

  ltx_link_framer #(.SYS_W(32), .AW(3)) dut (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .in_valid(in_valid),
    .in_data(in_data), .in_bc0(in_bc0), .lnk_clk(lnk_clk),
    .lnk_rst_n(lnk_rst_n), .tx_data(tx_data), .tx_k(tx_k), .tx_de(tx_de)
  );

  initial forever #10 sys_clk = ~sys_clk;
  initial begin
    #1.5;
    forever #3 lnk_clk = ~lnk_clk;
  end

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_w0  [512];
  logic [31:0] exp_w1  [512];
  bit          exp_bc0 [512];
  int sent = 0;
  int rx_count = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // CRC restated as a 64-bit message division, bit by bit
  function automatic logic [15:0] ref_crc(input logic [63:0] m);
    logic [15:0] c;
    logic fb;
    c = 16'hFFFF;
    for (int b = 63; b >= 0; b--) begin
      fb = c[15] ^ m[b];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  // link-side monitor
  bit          mon_on = 1'b0;
  bit          prev_de = 1'b0;
  logic [15:0] prev_data = 16'h50BC;
  logic [15:0] got [5];
  logic [7:0]  lead_hi = 8'h50;
  int          widx = 0;

  always @(negedge lnk_clk) begin
    if (mon_on) begin
      if (tx_de) begin
        if (!prev_de) begin
          widx = 0;
          lead_hi = prev_data[15:8];
        end
        chk(tx_k == 2'b00, "R4 data slot k flags", 64'(tx_k), 64'h0);
        if (widx < 5) got[widx] = tx_data;
        widx++;
        if (widx == 5) begin
          if (rx_count < sent) begin
            chk({got[0], got[1]} == exp_w0[rx_count], "R4 first word halves",
                {got[0], got[1]}, 64'(exp_w0[rx_count]));
            chk({got[2], got[3]} == exp_w1[rx_count], "R4 second word halves",
                {got[2], got[3]}, 64'(exp_w1[rx_count]));
            chk(got[4] == ref_crc({exp_w0[rx_count], exp_w1[rx_count]}), "R5 CRC word",
                64'(got[4]), 64'(ref_crc({exp_w0[rx_count], exp_w1[rx_count]})));
            chk(lead_hi == (exp_bc0[rx_count] ? 8'hC5 : 8'h50), "R6 lead comma marker",
                64'(lead_hi), 64'(exp_bc0[rx_count] ? 8'hC5 : 8'h50));
          end else begin
            chk(1'b0, "R7 unexpected extra frame", 64'(rx_count), 64'(sent));
          end
          rx_count++;
        end
        if (widx > 5) chk(1'b0, "R9 frame longer than five slots", 64'(widx), 64'd5);
      end else begin
        if (prev_de) chk(widx == 5, "R9 frame length", 64'(widx), 64'd5);
        chk(tx_k == 2'b01 && tx_data[7:0] == 8'hBC &&
            (tx_data[15:8] == 8'h50 || tx_data[15:8] == 8'hC5),
            "R1 comma on empty slot", {46'h0, tx_k, tx_data}, {46'h0, 2'b01, 16'h50BC});
      end
      prev_de = tx_de;
      prev_data = tx_data;
    end
  end

  task automatic send_word(input logic [31:0] d, input bit bc0);
    @(negedge sys_clk);
    in_valid = 1'b1;
    in_data  = d;
    in_bc0   = bc0;
  endtask

  task automatic idle_sys(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge sys_clk);
      in_valid = 1'b0;
      in_bc0   = 1'b0;
    end
  endtask

  task automatic send_frame(input logic [31:0] w0, input logic [31:0] w1,
                            input bit bc0, input bit bc0_second, input int gap);
    exp_w0[sent]  = w0;
    exp_w1[sent]  = w1;
    exp_bc0[sent] = bc0;
    sent++;
    send_word(w0, bc0);
    send_word(w1, bc0_second);
    if (gap > 0) idle_sys(gap);
  endtask

  function automatic logic [31:0] pat(input int i);
    case (i % 5)
      0: return 32'(i) * 32'h9E37_79B9;
      1: return 32'hFFFF_FFFF;
      2: return 32'h1 << (i % 32);
      3: return 32'h0000_0000;
      default: return {16'(i), ~16'(i)};
    endcase
  endfunction

  initial begin
    repeat (4) @(negedge sys_clk);
    // R1: reset state
    chk(tx_data == 16'h50BC, "R1 reset data", 64'(tx_data), 64'h50BC);
    chk(tx_k == 2'b01, "R1 reset k flags", 64'(tx_k), 64'h1);
    chk(tx_de == 1'b0, "R1 reset data-enable", 64'(tx_de), 64'h0);
    sys_rst_n = 1'b1;
    lnk_rst_n = 1'b1;
    mon_on = 1'b1;
    idle_sys(10);
    chk(rx_count == 0 && tx_de == 1'b0, "R1 idle after reset", 64'(rx_count), 64'h0);

    // R2/R3: half a frame must wait; the bc0 on the second word is ignored (R6)
    exp_w0[0] = 32'hCAFE_0001; exp_w1[0] = 32'h1234_ABCD; exp_bc0[0] = 1'b1;
    send_word(32'hCAFE_0001, 1'b1);
    idle_sys(40);
    chk(rx_count == 0, "R2 no frame from one word", 64'(rx_count), 64'h0);
    chk(tx_de == 1'b0, "R2 link still idle", 64'(tx_de), 64'h0);
    sent = 1;
    send_word(32'h1234_ABCD, 1'b1);
    idle_sys(20);
    chk(rx_count == 1, "R3 paired frame emitted", 64'(rx_count), 64'h1);

    // a frame with bc0 only on its second word
    send_frame(32'h0F0F_0F0F, 32'hF0F0_F0F0, 1'b0, 1'b1, 20);
    chk(rx_count == 2, "R6 second-word bc0 frame emitted", 64'(rx_count), 64'h2);

    // R7: sweep of patterns, gaps 0..3 and marker placements
    for (int i = 0; i < 120; i++) begin
      send_frame(pat(i), ~pat(i + 3) ^ (32'(i) << 8), (i % 5) == 0, (i % 7) == 3, i % 4);
    end
    idle_sys(1);
    for (int t = 0; t < 3000 && rx_count < sent; t++) @(negedge sys_clk);
    idle_sys(10);
    chk(rx_count == sent, "R7 all frames delivered once", 64'(rx_count), 64'(sent));
    chk(tx_de == 1'b0, "R1 idle after drain", 64'(tx_de), 64'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge sys_clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule